// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a processor's read request port and a synchronous memory array. It stretches every read so that it lasts a programmable number of processor clocks, which lets slow storage be read correctly at a high processor clock rate. The stretch is set by a 4-bit latency field in a 16-bit configuration register. An access lasts the field value plus one clock. Field values 0 to 4 suit processor clocks up to 20, 40, 60, 80 and 100 MHz. Value 5 gives a six-clock access that works at any clock rate. Any value above 5 is treated as 5.

The processor raises `req` for one cycle with `addr` while the controller is idle. The controller issues one read to the array in that same cycle. It then counts the programmed latency and raises `rdy` for exactly one cycle, with the word on `rdata`. The latency is captured when the access is accepted. A configuration write that lands during an access therefore only affects later accesses. The array model is a synchronous read port: data appears on the cycle after `mem_en`, and it holds that value until the next read.

The controller is a three-state machine:

- **IDLE** waits for `req`. On `req` it goes to **WAIT** if the latency field is 1 to 5, or straight to **DONE** if the field is 0.
- **WAIT** counts the remaining clocks down. It moves to **DONE** when the count reaches its last clock.
- **DONE** drives `rdy` and always returns to **IDLE**.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x503A. The latency field (bits 15:12) is 5, the safe six-clock setting, and the low bits are 0x3A.
- R2: A write with `cfg_we` high stores `cfg_wdata`, and the new value is visible on `cfg_rdata` in the next cycle.
- R3: If `req` is high in idle cycle c and the latency field F is 0 to 5, `rdy` is high in cycle c+F+1 and low in cycles c+1 to c+F.
- R4: A latency field of 6 to 15 gives the same timing as 5: `rdy` is high in cycle c+6.
- R5: `rdy` is high for exactly one cycle per access. In that cycle `rdata` equals the array word at the accepted address. `rdata` is 0 in every other cycle.
- R6: A configuration write made while an access is in progress does not change that access's latency. The next access uses the new value.
- R7: When a configuration write and an accepted `req` fall in the same cycle, that access uses the value held before the write.
- R8: `req` raised while an access is in progress is ignored: no array read is issued and no extra `rdy` follows.
- R9: In the cycle a request is accepted, `mem_en` is high and `mem_addr` equals `addr`. `mem_en` is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data; bits 15:12 hold the latency field |
| cfg_rdata | output | 16 | Current configuration register value |
| req | input | 1 | Read request, accepted only when idle |
| addr | input | 6 | Read word address |
| rdy | output | 1 | One-cycle read completion strobe |
| rdata | output | 16 | Read data, valid while `rdy` is high, otherwise 0 |
| mem_en | output | 1 | Array read enable |
| mem_addr | output | 6 | Array read address |
| mem_rdata | input | 16 | Array read data, valid the cycle after `mem_en` |

## Verification
Each fault in the internal state shows up at the ports within one access, that is, within at most seven cycles:

- A wrong countdown value or a bad clamp moves the `rdy` pulse to a cycle other than c+F+1.
- A state machine that fails to leave DONE gives a `rdy` pulse two or more cycles wide.
- A state machine that leaves IDLE too late lets a second `mem_en` through on a request made during an access.
- A latency that is read live instead of captured at acceptance shifts `rdy` in the very access during which the configuration was rewritten.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } fws_state_e;

    // largest honoured latency field value (six-clock access)
    localparam int unsigned SAFE_FIELD = 5;

endpackage

// File: rtl/fws_cfg_reg.sv
module fws_cfg_reg #(
    parameter int unsigned CFG_W     = 16,
    parameter int unsigned FIELD_LSB = 12,
    parameter int unsigned FIELD_W   = 4,
    parameter logic [CFG_W-1:0] RESET_VAL = 16'h503A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [CFG_W-1:0]   wdata_i,
    output logic [CFG_W-1:0]   rdata_o,
    output logic [FIELD_W-1:0] field_o
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RESET_VAL;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    assign rdata_o = cfg_q;
    assign field_o = cfg_q[FIELD_LSB +: FIELD_W];

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o == $past(wdata_i))); // R2

endmodule

// File: rtl/fws_lat_map.sv
module fws_lat_map
    import fws_pkg::*;
#(
    parameter int unsigned FIELD_W = 4,
    parameter int unsigned CNT_W   = 3
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [CNT_W-1:0]   lat_o
);

    localparam logic [FIELD_W-1:0] FIELD_MAX = FIELD_W'(SAFE_FIELD);
    localparam logic [CNT_W-1:0]   LAT_MAX   = CNT_W'(SAFE_FIELD);

    // values above the safe setting fall back to it
    always_comb begin
        if (field_i > FIELD_MAX) begin
            lat_o = LAT_MAX;
        end else begin
            lat_o = CNT_W'(field_i);
        end
    end

endmodule

// File: rtl/fws_seq.sv
module fws_seq
    import fws_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] lat_i,
    output logic             accept_o,
    output logic             rdy_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAFE_FIELD);

    fws_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic; latency is captured only on acceptance
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    cnt_d   = lat_i;
                    state_d = (lat_i == '0) ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                cnt_d = cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept_o = (state_q == ST_IDLE) && req_i;
        rdy_o    = (state_q == ST_DONE);
    end

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o); // R5

    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cnt_q > CNT_ONE)
            |=> (state_q == ST_WAIT && cnt_q == CNT_W'($past(cnt_q) - CNT_ONE))); // R3

    AST_WAIT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cnt_q == CNT_ONE) |=> rdy_o); // R3

endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl
    import fws_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CFG_W     = 16,
    parameter int unsigned FIELD_LSB = 12,
    parameter int unsigned FIELD_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              rdy,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned CNT_W = $clog2(SAFE_FIELD + 1);

    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   lat;
    logic               accept;

    fws_cfg_reg #(
        .CFG_W     (CFG_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_W   (FIELD_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .field_o (field)
    );

    fws_lat_map #(
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W)
    ) u_map (
        .field_i (field),
        .lat_o   (lat)
    );

    fws_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .lat_i    (lat),
        .accept_o (accept),
        .rdy_o    (rdy)
    );

    // one array read per accepted access; array output holds until next read
    assign mem_en   = accept;
    assign mem_addr = addr;
    assign rdata    = rdy ? mem_rdata : '0;

    AST_READ_BEFORE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en); // R9

endmodule

// File: tb/flash_wait_ctrl_test.sv
`timescale 1ns/1ps
module flash_wait_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req = 1'b0;
    logic [5:0]  addr = '0;
    logic        rdy;
    logic [15:0] rdata;
    logic        mem_en;
    logic [5:0]  mem_addr;
    logic [15:0] mem_q = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_wait_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req       (req),
        .addr      (addr),
        .rdy       (rdy),
        .rdata     (rdata),
        .mem_en    (mem_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_q)
    );

    function automatic logic [15:0] word_of(input logic [5:0] a);
        return (16'(a) * 16'd37) + 16'd1000;
    endfunction

    // synchronous array model
    always @(posedge clk) begin
        if (mem_en) mem_q <= word_of(mem_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R2 cfg readback", cfg_rdata, v);
    endtask

    // raises req for one idle cycle; returns at the first negedge after acceptance
    task automatic start_req(input logic [5:0] a);
        @(negedge clk);
        req = 1'b1;
        addr = a;
        #0.1;
        chk("R9 mem_en on accept", mem_en, 1);
        chk("R9 mem_addr on accept", mem_addr, a);
        @(negedge clk);
        req = 1'b0;
    endtask

    // current negedge counts as the first cycle
    task automatic wait_rdy(input int lat, input logic [5:0] a, input string tag);
        for (int k = 1; k <= lat; k++) begin
            if (k > 1) @(negedge clk);
            if (k < lat) begin
                chk({tag, " rdy early"}, rdy, 0);
                chk("R9 mem_en quiet", mem_en, 0);
            end else begin
                chk({tag, " rdy on time"}, rdy, 1);
                chk("R5 rdata on rdy", rdata, word_of(a));
            end
        end
        @(negedge clk);
        chk("R5 rdy single cycle", rdy, 0);
        chk("R5 rdata zero after", rdata, 0);
    endtask

    localparam int NVEC = 10;
    localparam logic [3:0] TF [NVEC] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4,
                                         4'd5, 4'd6, 4'd9, 4'd15, 4'd0};
    localparam logic [5:0] TA [NVEC] = '{6'd1, 6'd63, 6'd7, 6'd20, 6'd33,
                                         6'd0, 6'd12, 6'd45, 6'd58, 6'd2};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cfg", cfg_rdata, 16'h503A);
        chk("R5 reset rdy", rdy, 0);
        chk("R5 reset rdata", rdata, 0);
        chk("R9 reset mem_en", mem_en, 0);

        // reset latency is six clocks
        start_req(6'd9);
        wait_rdy(6, 6'd9, "R1 reset latency");

        // vector table: field value and address
        for (int i = 0; i < NVEC; i++) begin
            int lat;
            write_cfg({TF[i], 12'h03A});
            lat = (TF[i] > 4'd5) ? 6 : int'(TF[i]) + 1;
            start_req(TA[i]);
            wait_rdy(lat, TA[i], (TF[i] > 4'd5) ? "R4 clamp" : "R3 latency");
        end

        // R6: rewrite during an access
        write_cfg(16'h5000);
        start_req(6'd17);
        cfg_we = 1'b1;
        cfg_wdata = 16'h0000;
        chk("R6 rdy early", rdy, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_rdy(5, 6'd17, "R6 old latency kept");
        start_req(6'd18);
        wait_rdy(1, 6'd18, "R6 new latency used");

        // R7: write and accept in the same cycle
        write_cfg(16'h3000);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 16'h0000;
        req = 1'b1;
        addr = 6'd40;
        @(negedge clk);
        cfg_we = 1'b0;
        req = 1'b0;
        wait_rdy(4, 6'd40, "R7 prior value");
        chk("R7 write landed", cfg_rdata, 16'h0000);

        // R8: request during an access
        write_cfg(16'h3000);
        start_req(6'd25);
        req = 1'b1;
        addr = 6'd50;
        #0.1;
        chk("R8 no read while busy", mem_en, 0);
        @(negedge clk);
        req = 1'b0;
        wait_rdy(3, 6'd25, "R8 first access");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 no extra rdy", rdy, 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule